// File: doc/BRIEF.md
# Min/Max Averaging Lock Filter

This block is the final filtering stage of a digital frequency-acquisition loop. Once the coarse binary search has shrunk its step to one, the oscillator codeword no longer settles. It toggles around the true lock point as the phase detector keeps swinging between early and late. The filter samples that codeword on every reference tick and keeps the largest and smallest values it has seen. It also counts how many times the detector's early/late polarity has flipped from one tick to the next.

When the configured number of flips has been seen, the filter latches the midpoint of the recorded extremes as the locked code and raises a locked flag. Both outputs then hold until the control unit drops the enable or the block is reset. A fresh acquisition starts from scratch after the enable is raised again.

Top module: `minmax_lock_filter`

## Requirements
- R1: Out of reset, `locked_o` is 0 and `lock_code_o` is 0.
- R2: Averaging is entered only on a cycle where `tick_i`, `enable_i` and `step_one_i` are all 1. Ticks while `step_one_i` is 0 never lead to lock, however often the polarity toggles.
- R3: On entry, both the recorded maximum and the recorded minimum take the codeword sampled on the entry tick.
- R4: While averaging, the extremes are updated only from codewords present on tick cycles. Codeword values between ticks have no effect on the locked code.
- R5: A reversal is a tick whose `polarity_i` differs from `polarity_i` on the previous tick (the entry tick is the first reference). `locked_o` rises in the cycle after the tick that brings the count to INV_TARGET (default 6), and not earlier.
- R6: The locked code is (max + min) / 2. The sum is formed one bit wider than the codeword, and the division truncates. With 8-bit codes, max 255 and min 254 give 254.
- R7: While `locked_o` is 1 and `enable_i` stays 1, `lock_code_o` and `locked_o` hold, whatever `code_i`, `polarity_i`, `tick_i` or `step_one_i` do.
- R8: A cycle with `enable_i` at 0 clears `locked_o` and `lock_code_o` to 0 and discards the reversal count. The next acquisition needs a full INV_TARGET fresh reversals.
- R9: Ticks whose polarity equals that of the previous tick do not count as reversals.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Filter enable from the control unit; low clears the filter |
| step_one_i | input | 1 | High when the search step has reached one |
| tick_i | input | 1 | One-cycle pulse per reference period; sampling strobe |
| polarity_i | input | 1 | Detector decision: 1 = oscillator late, 0 = early |
| code_i | input | CODE_W | Oscillator codeword being averaged |
| lock_code_o | output | CODE_W | Midpoint of recorded max and min once locked |
| locked_o | output | 1 | Lock achieved |

## Verification
Every result is registered, so entry, extreme updates, the reversal count, the lock flag and the locked code all appear one clock after the edge that samples the tick. Clearing by a low enable likewise shows one clock after the edge where enable is low. The bench changes inputs on the falling edge and holds each tick for exactly one rising edge. It reads the outputs on the following falling edge, half a period after the register stage, so each check sees exactly the state produced by that tick. The lock checks also sample right after the tick just before the final reversal, to prove the flag is not early.

// File: rtl/mmlf_pkg.sv
package mmlf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_TRACK  = 2'd1,
    ST_LOCKED = 2'd2
  } mmlf_state_e;
endpackage

// File: rtl/mmlf_extrema.sv
module mmlf_extrema #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         upd_i,
  input  logic [W-1:0] code_i,
  output logic [W-1:0] max_o,
  output logic [W-1:0] min_o,
  output logic [W-1:0] max_nxt_o,
  output logic [W-1:0] min_nxt_o
);
  logic [W-1:0] max_q, min_q, max_d, min_d;

  always_comb begin
    max_d = max_q;
    min_d = min_q;
    if (load_i) begin
      max_d = code_i;
      min_d = code_i;
    end else if (upd_i) begin
      if (code_i > max_q) max_d = code_i;
      if (code_i < min_q) min_d = code_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      max_q <= '0;
      min_q <= '0;
    end else if (load_i || upd_i) begin
      max_q <= max_d;
      min_q <= min_d;
    end
  end

  assign max_o     = max_q;
  assign min_o     = min_q;
  assign max_nxt_o = max_d;
  assign min_nxt_o = min_d;
endmodule

// File: rtl/mmlf_reversal.sv
module mmlf_reversal #(
  parameter int TARGET = 6,
  parameter int CW     = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          arm_i,
  input  logic          upd_i,
  input  logic          pol_i,
  output logic [CW-1:0] count_o,
  output logic          hit_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ref_q, ref_d;
  logic          flip;

  assign flip = upd_i && (pol_i != ref_q);

  always_comb begin
    cnt_d = cnt_q;
    ref_d = ref_q;
    if (clear_i) begin
      cnt_d = '0;
    end else if (arm_i) begin
      cnt_d = '0;
      ref_d = pol_i;
    end else if (upd_i) begin
      ref_d = pol_i;
      if (flip && (cnt_q != CW'(TARGET))) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ref_q <= 1'b0;
    end else if (clear_i || arm_i || upd_i) begin
      cnt_q <= cnt_d;
      ref_q <= ref_d;
    end
  end

  assign count_o = cnt_q;
  assign hit_o   = flip && (cnt_q == CW'(TARGET - 1));
endmodule

// File: rtl/mmlf_midpoint.sv
module mmlf_midpoint #(
  parameter int W = 8
) (
  input  logic [W-1:0] hi_i,
  input  logic [W-1:0] lo_i,
  output logic [W-1:0] mid_o
);
  logic [W:0] sum;
  assign sum   = {1'b0, hi_i} + {1'b0, lo_i};
  assign mid_o = sum[W:1];
endmodule

// File: rtl/minmax_lock_filter.sv
module minmax_lock_filter
  import mmlf_pkg::*;
#(
  parameter int CODE_W     = 8,
  parameter int INV_TARGET = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              step_one_i,
  input  logic              tick_i,
  input  logic              polarity_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [CODE_W-1:0] lock_code_o,
  output logic              locked_o
);
  localparam int CNT_W = $clog2(INV_TARGET + 1);

  mmlf_state_e       state_q, state_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic              sample, enter, upd, hit;
  logic [CODE_W-1:0] ext_max, ext_min, max_nxt, min_nxt, mid;
  logic [CNT_W-1:0]  rev_cnt;

  assign sample = tick_i && enable_i;
  assign enter  = sample && step_one_i && (state_q == ST_IDLE);
  assign upd    = sample && (state_q == ST_TRACK);

  mmlf_extrema #(.W(CODE_W)) u_ext (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(enter), .upd_i(upd),
    .code_i(code_i), .max_o(ext_max), .min_o(ext_min),
    .max_nxt_o(max_nxt), .min_nxt_o(min_nxt)
  );

  mmlf_reversal #(.TARGET(INV_TARGET), .CW(CNT_W)) u_rev (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(!enable_i), .arm_i(enter),
    .upd_i(upd), .pol_i(polarity_i), .count_o(rev_cnt), .hit_o(hit)
  );

  mmlf_midpoint #(.W(CODE_W)) u_mid (
    .hi_i(max_nxt), .lo_i(min_nxt), .mid_o(mid)
  );

  always_comb begin
    state_d = state_q;
    code_d  = code_q;
    if (!enable_i) begin
      state_d = ST_IDLE;
      code_d  = '0;
    end else begin
      case (state_q)
        ST_IDLE:   if (enter) state_d = ST_TRACK;
        ST_TRACK:  if (hit) begin
                     state_d = ST_LOCKED;
                     code_d  = mid;
                   end
        ST_LOCKED: state_d = ST_LOCKED;
        default:   state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      code_q  <= '0;
    end else begin
      state_q <= state_d;
      code_q  <= code_d;
    end
  end

  assign lock_code_o = code_q;
  assign locked_o    = (state_q == ST_LOCKED);
endmodule

// File: rtl/mmlf_checker.sv
module mmlf_checker #(
  parameter int CODE_W     = 8,
  parameter int INV_TARGET = 6,
  parameter int CNT_W      = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              enable_i,
  input logic              tick_i,
  input logic              locked_o,
  input logic [CODE_W-1:0] lock_code_o,
  input logic [CODE_W-1:0] trk_max,
  input logic [CODE_W-1:0] trk_min,
  input logic [CNT_W-1:0]  trk_cnt,
  input logic [1:0]        trk_state
);
  // R4
  max_ge_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trk_state != 2'd0) |-> (trk_max >= trk_min));

  // R6
  code_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |-> (lock_code_o >= trk_min && lock_code_o <= trk_max));

  // R7
  lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_o && enable_i) |=> (locked_o && $stable(lock_code_o)));

  // R8
  disable_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (!locked_o && lock_code_o == '0));

  // R5
  lock_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> $past(tick_i && enable_i));

  // R5
  count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trk_cnt <= CNT_W'(INV_TARGET));
endmodule

bind minmax_lock_filter mmlf_checker #(
  .CODE_W(CODE_W), .INV_TARGET(INV_TARGET), .CNT_W(CNT_W)
) u_mmlf_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .enable_i(enable_i), .tick_i(tick_i),
  .locked_o(locked_o), .lock_code_o(lock_code_o),
  .trk_max(ext_max), .trk_min(ext_min), .trk_cnt(rev_cnt),
  .trk_state(state_q)
);

// File: tb/minmax_lock_filter_bench.sv
`timescale 1ns/1ps
module minmax_lock_filter_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0, step1 = 1'b0, tick = 1'b0, pol = 1'b0;
  logic [7:0] code = 8'd0;
  logic [7:0] lcode;
  logic       lkd;
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  minmax_lock_filter u_minmax_lock_filter (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .step_one_i(step1),
    .tick_i(tick), .polarity_i(pol), .code_i(code),
    .lock_code_o(lcode), .locked_o(lkd)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tk(input int c, input logic p);
    code = 8'(c); pol = p; tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic idle(input int c);
    code = 8'(c);
    @(negedge clk);
  endtask

  task automatic restart();
    en = 1'b0; @(negedge clk);
    chk("R8 locked cleared", int'(lkd), 0);
    chk("R8 code cleared", int'(lcode), 0);
    en = 1'b1;
  endtask

  task automatic t_reset();
    chk("R1 locked", int'(lkd), 0);
    chk("R1 code", int'(lcode), 0);
  endtask

  task automatic t_no_step();
    en = 1'b1; step1 = 1'b0;
    for (int i = 0; i < 10; i++) tk(40 + i, logic'(i % 2));
    chk("R2 no lock without step one", int'(lkd), 0);
  endtask

  task automatic t_basic();
    step1 = 1'b1;
    tk(200, 1'b0);
    tk(150, 1'b1);
    idle(255); idle(0);
    tk(180, 1'b0); tk(170, 1'b1); tk(160, 1'b0); tk(155, 1'b1);
    chk("R5 not locked after five", int'(lkd), 0);
    tk(165, 1'b0);
    chk("R5 locked after six", int'(lkd), 1);
    chk("R3 R4 midpoint 175", int'(lcode), 175);
  endtask

  task automatic t_hold();
    step1 = 1'b0;
    tk(0, 1'b1); tk(255, 1'b0); idle(9); tk(3, 1'b1);
    chk("R7 still locked", int'(lkd), 1);
    chk("R7 code held", int'(lcode), 175);
  endtask

  task automatic t_disable();
    restart();
    step1 = 1'b1;
    tk(100, 1'b0); tk(100, 1'b1); tk(100, 1'b0); tk(100, 1'b1);
    restart();
    tk(50, 1'b0);
    tk(52, 1'b1); tk(50, 1'b0); tk(52, 1'b1); tk(50, 1'b0); tk(52, 1'b1);
    chk("R8 count restarted", int'(lkd), 0);
    tk(51, 1'b0);
    chk("R8 relock", int'(lkd), 1);
    chk("R8 relock code", int'(lcode), 51);
  endtask

  task automatic t_repeat();
    restart();
    tk(10, 1'b1);
    for (int i = 0; i < 10; i++) tk(20, 1'b1);
    chk("R9 same polarity no count", int'(lkd), 0);
    tk(10, 1'b0); tk(10, 1'b1); tk(10, 1'b0); tk(10, 1'b1); tk(10, 1'b0);
    chk("R9 five reversals", int'(lkd), 0);
    tk(11, 1'b1);
    chk("R9 locked", int'(lkd), 1);
    chk("R9 code 15", int'(lcode), 15);
  endtask

  task automatic t_wide();
    restart();
    tk(255, 1'b0);
    tk(254, 1'b1); tk(255, 1'b0); tk(254, 1'b1); tk(255, 1'b0); tk(254, 1'b1);
    tk(255, 1'b0);
    chk("R6 locked", int'(lkd), 1);
    chk("R6 wide sum truncated", int'(lcode), 254);
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_no_step();
    t_basic();
    t_hold();
    t_disable();
    t_repeat();
    t_wide();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule